// File: doc/BRIEF.md
# Per-Timeslot Transmit Signaling State Selector

This block produces the four-bit channel-associated signaling code for each time slot of one transmit link of up to 32 slots. Software programs one small register per slot. The register holds a two-bit state mode and a default signaling code. A two-bit link-level select chooses where the codes come from: the host registers themselves, or a signaling bit stream taken from either the receive system side or the receive line side.

When a receive source is selected, the block assembles a code for each slot from bits sampled at fixed frames of the superframe. An external framer provides the frame number and a superframe-pair phase. How many bits are gathered, and how they are expanded to four, depends on the slot's mode. Until a slot has assembled its first complete code, the block drives that slot's programmed default code. Any slot can be read through a combinational lookup port.

Top module: `sig_state_sel`

## Requirements
- R1: After reset every slot has mode 00, default code 0000, no assembled code and valid flag 0, so `outCode` reads 0000 and `outValid` reads 0 for any slot.
- R2: A write with `cfgWe` loads slot `cfgSlot` from `cfgData`. Bits 6:5 hold the mode (00 sixteen-state, 01 four-state, 10 no signaling, 11 two-state), bit 4 is ignored, and bits 3:0 hold the default code with D in bit 3, C in bit 2, B in bit 1 and A in bit 0. The write clears that slot's valid flag and restarts its collection. When a write and a sample hit the same slot in the same cycle, the write wins and the sample is dropped.
- R3: `srcSel` 00 or 11 selects the host. Under host source `outCode` is the slot's register code and no collection takes place. `srcSel` 01 takes sampled bits from `sysBit` and 10 takes them from `lineBit`.
- R4: Under a receive source, a slot whose valid flag is 0 drives its register default code on `outCode`. Once the flag is 1 it drives the assembled code.
- R5: Two-state slot: a sample at frame index 5 completes a code with the bit copied into all four positions and sets valid. Both become visible on the cycle after the sample.
- R6: Four-state slot: a sample at frame index 5 gives A and a later sample at frame index 11 gives B. Together they complete the code {B,A,B,A}. A frame-11 sample with no A captured since the last completion or restart is dropped.
- R7: Sixteen-state slot: the four bits come from frame 5 with phase 0 (A), frame 11 with phase 0 (B), frame 5 with phase 1 (C) and frame 11 with phase 1 (D), in that order. They complete {D,C,B,A}. A sample out of this order restarts collection, and a phase-0 frame-5 sample always starts a new collection.
- R8: No-signaling slot: samples have no effect, the valid flag stays 0 and `outCode` shows the default code.
- R9: Slots are independent. A sample or write for one slot leaves every other slot's code and flag unchanged.
- R10: Samples at frame indices other than 5 and 11 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Slot register write strobe |
| cfgSlot | input | 5 | Slot index for the write |
| cfgData | input | 7 | Mode [6:5], unused [4], default DCBA [3:0] |
| srcSel | input | 2 | Signaling source: 00/11 host, 01 system, 10 line |
| smpValid | input | 1 | A signaling sample is presented this cycle |
| smpSlot | input | 5 | Slot the sample belongs to |
| smpFrame | input | 4 | Frame index within the superframe, 0 to 11 |
| smpPhase | input | 1 | Superframe within a pair: 0 first, 1 second |
| sysBit | input | 1 | Signaling bit from the receive system side |
| lineBit | input | 1 | Signaling bit from the receive line side |
| rdSlot | input | 5 | Slot to read out |
| outCode | output | 4 | Code for `rdSlot`, D in bit 3 down to A in bit 0 |
| outValid | output | 1 | `rdSlot` has an assembled code |

## Verification
The bench runs a sixteen-state collection that first sees a second-superframe bit with no preceding first-superframe bits. A design that did not restart would take that bit as C and complete a wrong code. It sends a four-state B before any A and checks that valid stays low, and it writes a slot in the same cycle that slot is sampled. A design that let the sample win would raise valid right after a reprogram. It also checks that frames other than 5 and 11, no-signaling slots and host source leave codes alone, and that the system and line inputs are not swapped.

// File: rtl/sig_state_pkg.sv
package sig_state_pkg;
  typedef enum logic [1:0] {
    MODE_SIXTEEN = 2'b00,
    MODE_FOUR    = 2'b01,
    MODE_NONE    = 2'b10,
    MODE_TWO     = 2'b11
  } sigMode_t;

  localparam int CodeW  = 4;
  localparam int StageW = 2;

  typedef struct packed {
    logic                cfgWe;
    logic                capWe;
    logic [StageW-1:0]   capStage;
    logic [CodeW-1:0]    capPart;
    logic                codeWe;
    logic [CodeW-1:0]    codeVal;
  } sigStrobe_t;
endpackage

// File: rtl/sig_state_ctrl.sv
module sig_state_ctrl
  import sig_state_pkg::*;
#(
  parameter int SlotW  = 5,
  parameter int FrameW = 4,
  parameter int FrameA = 5,
  parameter int FrameB = 11
) (
  input  logic                     cfgWe,
  input  logic [SlotW-1:0]         cfgSlot,
  input  logic [1:0]               srcSel,
  input  logic                     smpValid,
  input  logic [SlotW-1:0]         smpSlot,
  input  logic [FrameW-1:0]        smpFrame,
  input  logic                     smpPhase,
  input  logic                     sysBit,
  input  logic                     lineBit,
  input  sigMode_t                 curMode,
  input  logic [StageW-1:0]        curStage,
  input  logic [CodeW-1:0]         curPart,
  output sigStrobe_t               strobe
);
  logic rxSrc, act, bitIn, atA, atB;

  assign rxSrc = (srcSel == 2'b01) || (srcSel == 2'b10);
  assign bitIn = (srcSel == 2'b01) ? sysBit : lineBit;
  assign act   = smpValid && rxSrc && !(cfgWe && (cfgSlot == smpSlot));
  assign atA   = (smpFrame == FrameW'(FrameA));
  assign atB   = (smpFrame == FrameW'(FrameB));

  always_comb begin
    strobe          = '0;
    strobe.cfgWe    = cfgWe;
    strobe.capPart  = curPart;
    if (act && (atA || atB)) begin
      unique case (curMode)
        MODE_TWO: begin
          if (atA) begin
            strobe.capWe   = 1'b1;
            strobe.codeWe  = 1'b1;
            strobe.codeVal = {CodeW{bitIn}};
          end
        end
        MODE_FOUR: begin
          strobe.capWe = 1'b1;
          if (atA) begin
            strobe.capStage = 2'd1;
            strobe.capPart  = {3'b000, bitIn};
          end else if (curStage == 2'd1) begin
            strobe.codeWe  = 1'b1;
            strobe.codeVal = {bitIn, curPart[0], bitIn, curPart[0]};
          end
        end
        MODE_SIXTEEN: begin
          strobe.capWe = 1'b1;
          if (atA && !smpPhase) begin
            strobe.capStage = 2'd1;
            strobe.capPart  = {3'b000, bitIn};
          end else if (atB && !smpPhase && curStage == 2'd1) begin
            strobe.capStage = 2'd2;
            strobe.capPart  = {2'b00, bitIn, curPart[0]};
          end else if (atA && smpPhase && curStage == 2'd2) begin
            strobe.capStage = 2'd3;
            strobe.capPart  = {1'b0, bitIn, curPart[1:0]};
          end else if (atB && smpPhase && curStage == 2'd3) begin
            strobe.codeWe  = 1'b1;
            strobe.codeVal = {bitIn, curPart[2:0]};
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sig_state_dp.sv
module sig_state_dp
  import sig_state_pkg::*;
#(
  parameter int NumSlots = 32,
  parameter int SlotW    = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  sigStrobe_t          strobe,
  input  logic [SlotW-1:0]    cfgSlot,
  input  logic [1:0]          cfgMode,
  input  logic [CodeW-1:0]    cfgDflt,
  input  logic [SlotW-1:0]    smpSlot,
  input  logic [SlotW-1:0]    rdSlot,
  input  logic                hostSrc,
  output sigMode_t            curMode,
  output logic [StageW-1:0]   curStage,
  output logic [CodeW-1:0]    curPart,
  output logic [CodeW-1:0]    outCode,
  output logic                outValid
);
  logic [1:0]        modeQ  [NumSlots];
  logic [CodeW-1:0]  dfltQ  [NumSlots];
  logic [StageW-1:0] stageQ [NumSlots];
  logic [CodeW-1:0]  partQ  [NumSlots];
  logic [CodeW-1:0]  codeQ  [NumSlots];
  logic              validQ [NumSlots];

  for (genvar s = 0; s < NumSlots; s++) begin : g_slot
    logic wrHit, capHit;
    assign wrHit  = strobe.cfgWe && (cfgSlot == SlotW'(s));
    assign capHit = strobe.capWe && (smpSlot == SlotW'(s));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        modeQ[s]  <= MODE_SIXTEEN;
        dfltQ[s]  <= '0;
        stageQ[s] <= '0;
        partQ[s]  <= '0;
        codeQ[s]  <= '0;
        validQ[s] <= 1'b0;
      end else if (wrHit) begin
        modeQ[s]  <= cfgMode;
        dfltQ[s]  <= cfgDflt;
        stageQ[s] <= '0;
        partQ[s]  <= '0;
        validQ[s] <= 1'b0;
      end else if (capHit) begin
        stageQ[s] <= strobe.capStage;
        partQ[s]  <= strobe.capPart;
        if (strobe.codeWe) begin
          codeQ[s]  <= strobe.codeVal;
          validQ[s] <= 1'b1;
        end
      end
    end
  end

  assign curMode  = sigMode_t'(modeQ[smpSlot]);
  assign curStage = stageQ[smpSlot];
  assign curPart  = partQ[smpSlot];

  assign outValid = validQ[rdSlot];
  assign outCode  = (hostSrc || !validQ[rdSlot]) ? dfltQ[rdSlot] : codeQ[rdSlot];
endmodule

// File: rtl/sig_state_sel.sv
module sig_state_sel
  import sig_state_pkg::*;
#(
  parameter int NumSlots = 32,
  parameter int FrameW   = 4,
  parameter int FrameA   = 5,
  parameter int FrameB   = 11,
  localparam int SlotW   = $clog2(NumSlots)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [SlotW-1:0]  cfgSlot,
  input  logic [6:0]        cfgData,
  input  logic [1:0]        srcSel,
  input  logic              smpValid,
  input  logic [SlotW-1:0]  smpSlot,
  input  logic [FrameW-1:0] smpFrame,
  input  logic              smpPhase,
  input  logic              sysBit,
  input  logic              lineBit,
  input  logic [SlotW-1:0]  rdSlot,
  output logic [3:0]        outCode,
  output logic              outValid
);
  sigStrobe_t        strobe;
  sigMode_t          curMode;
  logic [StageW-1:0] curStage;
  logic [CodeW-1:0]  curPart;
  logic              hostSrc;
  logic              unusedCfgBit;

  assign unusedCfgBit = cfgData[4];
  assign hostSrc      = (srcSel == 2'b00) || (srcSel == 2'b11);

  sig_state_ctrl #(
    .SlotW(SlotW), .FrameW(FrameW), .FrameA(FrameA), .FrameB(FrameB)
  ) ctrlI (
    .cfgWe(cfgWe), .cfgSlot(cfgSlot), .srcSel(srcSel),
    .smpValid(smpValid), .smpSlot(smpSlot), .smpFrame(smpFrame),
    .smpPhase(smpPhase), .sysBit(sysBit), .lineBit(lineBit),
    .curMode(curMode), .curStage(curStage), .curPart(curPart),
    .strobe(strobe)
  );

  sig_state_dp #(.NumSlots(NumSlots), .SlotW(SlotW)) dpI (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cfgSlot(cfgSlot), .cfgMode(cfgData[6:5]), .cfgDflt(cfgData[3:0]),
    .smpSlot(smpSlot), .rdSlot(rdSlot), .hostSrc(hostSrc),
    .curMode(curMode), .curStage(curStage), .curPart(curPart),
    .outCode(outCode), .outValid(outValid)
  );
endmodule

// File: rtl/sig_state_sel_chk.sv
module sig_state_sel_chk #(
  parameter int NumSlots = 32,
  parameter int FrameW   = 4,
  localparam int SlotW   = $clog2(NumSlots)
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWe,
  input logic [SlotW-1:0]  cfgSlot,
  input logic [6:0]        cfgData,
  input logic [1:0]        srcSel,
  input logic              smpValid,
  input logic [FrameW-1:0] smpFrame,
  input logic [SlotW-1:0]  rdSlot,
  input logic [3:0]        outCode,
  input logic              outValid
);
  logic hostSel;
  assign hostSel = (srcSel == 2'b00) || (srcSel == 2'b11);

  // R2, R3: under host source a written slot shows its new default next cycle
  p_wr_default_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && hostSel && cfgSlot == rdSlot) |=>
      ($stable(rdSlot) && hostSel) -> (outCode == $past(cfgData[3:0])));

  // R2: a write clears the slot's valid flag
  p_wr_clears_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgSlot == rdSlot) |=> $stable(rdSlot) -> !outValid);

  // R3: under host source with no write, the flag of a held slot does not move
  p_host_freeze_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgWe && hostSel) |=> $stable(rdSlot) -> $stable(outValid));

  // R9, R10: with no write and no sample, a held slot's output does not move
  p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgWe && !smpValid) |=> ($stable(rdSlot) && $stable(srcSel)) ->
      ($stable(outCode) && $stable(outValid)));

  // R10: frame index stays within one superframe
  p_frame_range_r10: assert property (@(posedge clk) disable iff (!rstN)
    smpValid |-> (smpFrame < FrameW'(12)));
endmodule

bind sig_state_sel sig_state_sel_chk #(.NumSlots(NumSlots), .FrameW(FrameW)) chkI (.*);

// File: tb/sig_state_sel_tb.sv
module sig_state_sel_tb_top;
  localparam int ClkPeriod = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWe = 1'b0;
  logic [4:0] cfgSlot = '0;
  logic [6:0] cfgData = '0;
  logic [1:0] srcSel = 2'b00;
  logic       smpValid = 1'b0;
  logic [4:0] smpSlot = '0;
  logic [3:0] smpFrame = '0;
  logic       smpPhase = 1'b0;
  logic       sysBit = 1'b0;
  logic       lineBit = 1'b0;
  logic [4:0] rdSlot = '0;
  logic [3:0] outCode;
  logic       outValid;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(ClkPeriod/2) clk = ~clk;

  sig_state_sel dut_i (.*);

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic readSlot(input int s, input string req, input int expCode, input int expVal);
    rdSlot = 5'(s);
    #1;
    check({req, " code"}, outCode, expCode);
    check({req, " valid"}, outValid, expVal);
  endtask

  task automatic wrSlot(input int s, input int mode, input int dflt);
    cfgWe = 1'b1; cfgSlot = 5'(s); cfgData = {2'(mode), 1'b1, 4'(dflt)};
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic sample(input int s, input int fr, input int ph, input int sb, input int lb);
    smpValid = 1'b1; smpSlot = 5'(s); smpFrame = 4'(fr); smpPhase = ph[0];
    sysBit = sb[0]; lineBit = lb[0];
    @(negedge clk);
    smpValid = 1'b0;
  endtask

  task automatic testReset();
    readSlot(0, "R1 slot0", 0, 0);
    readSlot(31, "R1 slot31", 0, 0);
  endtask

  task automatic testHost();
    srcSel = 2'b00;
    wrSlot(3, 0, 4'hA);
    readSlot(3, "R2 host default bit4 ignored", 4'hA, 0);
    sample(3, 5, 0, 1, 1); sample(3, 11, 0, 1, 1);
    sample(3, 5, 1, 1, 1); sample(3, 11, 1, 1, 1);
    readSlot(3, "R3 host no collection", 4'hA, 0);
  endtask

  task automatic testTwoState();
    srcSel = 2'b01;
    wrSlot(4, 3, 4'h5);
    readSlot(4, "R4 default before valid", 4'h5, 0);
    sample(4, 3, 0, 1, 0);
    readSlot(4, "R10 frame 3 ignored", 4'h5, 0);
    sample(4, 5, 0, 1, 0);
    readSlot(4, "R5 two-state sys", 4'hF, 1);
    srcSel = 2'b10;
    wrSlot(4, 3, 4'h5);
    readSlot(4, "R2 rewrite clears valid", 4'h5, 0);
    sample(4, 5, 0, 1, 0);
    readSlot(4, "R3 line source two-state", 4'h0, 1);
  endtask

  task automatic testFourState();
    srcSel = 2'b01;
    wrSlot(7, 1, 4'h8);
    sample(7, 11, 0, 1, 1);
    readSlot(7, "R6 B without A dropped", 4'h8, 0);
    sample(7, 5, 0, 1, 0);
    readSlot(7, "R6 A alone not complete", 4'h8, 0);
    sample(7, 11, 0, 0, 1);
    readSlot(7, "R6 four-state code", 4'h5, 1);
  endtask

  task automatic testSixteen();
    srcSel = 2'b01;
    wrSlot(9, 0, 4'h2);
    sample(9, 5, 1, 1, 0);
    sample(9, 11, 1, 1, 0);
    readSlot(9, "R7 out of order restarts", 4'h2, 0);
    sample(9, 5, 0, 1, 0);
    sample(9, 11, 0, 0, 1);
    sample(9, 5, 1, 1, 0);
    readSlot(9, "R7 three bits not complete", 4'h2, 0);
    sample(9, 11, 1, 1, 0);
    readSlot(9, "R7 sixteen-state code", 4'hD, 1);
  endtask

  task automatic testNone();
    srcSel = 2'b01;
    wrSlot(10, 2, 4'h6);
    sample(10, 5, 0, 1, 1); sample(10, 11, 0, 1, 1);
    readSlot(10, "R8 no signaling", 4'h6, 0);
  endtask

  task automatic testIndependence();
    srcSel = 2'b01;
    readSlot(9, "R9 slot9 kept", 4'hD, 1);
    readSlot(7, "R9 slot7 kept", 4'h5, 1);
    readSlot(11, "R9 slot11 untouched", 4'h0, 0);
  endtask

  task automatic testWriteWins();
    srcSel = 2'b01;
    cfgWe = 1'b1; cfgSlot = 5'd12; cfgData = 7'b1100111;
    smpValid = 1'b1; smpSlot = 5'd12; smpFrame = 4'd5; smpPhase = 1'b0;
    sysBit = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0; smpValid = 1'b0;
    readSlot(12, "R2 write wins over sample", 4'h7, 0);
    srcSel = 2'b11;
    readSlot(9, "R3 select 11 is host", 4'h2, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testHost();
    testTwoState();
    testFourState();
    testSixteen();
    testNone();
    testIndependence();
    testWriteWins();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule